// File: doc/BRIEF.md
# Shared-Select Multi-Channel Mux with Gated Hold

This block carries a small group of independent bit channels. Each channel chooses one of four data bits, and a single two-bit select field steers every channel at once. The chosen bit then passes through a storage stage. Two hold requests are combined to control that stage. While neither request is raised, the stage is transparent and the outputs track the multiplexers in the same cycle. As soon as either request rises, the outputs freeze.

Each channel drives a true output and a complementary output. A reset input clears every stored bit asynchronously and wins over transparent mode. The storage is built from edge-triggered flops, so the block needs no latch cells. A hold register samples the multiplexer result on every rising clock edge while the stage is open. While the stage is closed, the outputs are taken from that register. Inputs are expected to change away from the rising clock edge.

Top module: `mux_hold_bank`

## Requirements
- R1: The select field picks, in every channel at once, the bit given by {sel[1],sel[0]}: 00 picks din_a, 01 picks din_b, 10 picks din_c and 11 picks din_d.
- R2: The stage is closed when hold_x is 1, when hold_y is 1, or when both are 1. It is open only when both are 0.
- R3: While the stage is open and reset is low, q equals the selected bits in the same cycle, with no clock edge in between.
- R4: While the stage is closed, q keeps the value it showed during the last open cycle. That value is captured at each rising clock edge while the stage is open.
- R5: Changes on din_a..din_d or sel while the stage is closed leave q and q_n unchanged.
- R6: While rst is 1, q is all zeros and q_n is all ones at once, whatever the data, select and hold inputs are doing, including in transparent mode.
- R7: When rst falls while the stage is closed, q stays all zeros until the stage opens again.
- R8: q_n is always the bitwise complement of q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the hold register |
| rst | input | 1 | Asynchronous clear, active high |
| din_a | input | NCH | Data choice 00, one bit per channel |
| din_b | input | NCH | Data choice 01, one bit per channel |
| din_c | input | NCH | Data choice 10, one bit per channel |
| din_d | input | NCH | Data choice 11, one bit per channel |
| sel | input | 2 | Select field shared by all channels |
| hold_x | input | 1 | Hold request, active high |
| hold_y | input | 1 | Hold request, active high |
| q | output | NCH | True outputs |
| q_n | output | NCH | Complementary outputs |

## Verification
In transparent mode the outputs are due in the same cycle as a change on data or select, with no register on the path. Reset also acts at once. A held value comes from the register load at the last rising edge before the stage closed. The bench drives every input one time unit after a rising edge and samples a few units later, before the next edge. Its reference model reloads its own hold value at each edge where the previous step was open and reset was low, which mirrors the one register on the hold path.

// File: rtl/mux_hold_pkg.sv
package mux_hold_pkg;

    // Encoding of the shared select field
    typedef enum logic [1:0] {
        PICK_A = 2'b00,
        PICK_B = 2'b01,
        PICK_C = 2'b10,
        PICK_D = 2'b11
    } pick_e;

    // The four candidate bits of one channel
    typedef struct packed {
        logic a;
        logic b;
        logic c;
        logic d;
    } quad_t;

    function automatic logic pick_bit(input quad_t cand, input pick_e s);
        logic r;
        case (s)
            PICK_A:  r = cand.a;
            PICK_B:  r = cand.b;
            PICK_C:  r = cand.c;
            default: r = cand.d;
        endcase
        return r;
    endfunction

    // Stage is open only when no hold request is raised
    function automatic logic stage_open(input logic rq0, input logic rq1);
        return !(rq0 | rq1);
    endfunction

endpackage

// File: rtl/quad_selector.sv
module quad_selector
    import mux_hold_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic [NCH-1:0] da,
    input  logic [NCH-1:0] db,
    input  logic [NCH-1:0] dc,
    input  logic [NCH-1:0] dd,
    input  pick_e          sel,
    output logic [NCH-1:0] y
);

    // One selector per channel, all steered by the same field
    for (genvar g = 0; g < NCH; g++) begin : g_lane
        quad_t cand;
        assign cand  = '{a: da[g], b: db[g], c: dc[g], d: dd[g]};
        assign y[g]  = pick_bit(cand, sel);
    end

endmodule

// File: rtl/hold_gate.sv
module hold_gate
    import mux_hold_pkg::*;
(
    input  logic rq0,
    input  logic rq1,
    output logic open
);

    assign open = stage_open(rq0, rq1);

endmodule

// File: rtl/chan_store.sv
module chan_store #(
    parameter int NCH = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           open,
    input  logic [NCH-1:0] d,
    output logic [NCH-1:0] q
);

    logic [NCH-1:0] held;

    // Capture while open; the async clear empties the store
    always_ff @(posedge clk or posedge rst) begin
        if (rst)
            held <= '0;
        else if (open)
            held <= d;
    end

    always_comb begin
        if (rst)
            q = '0;
        else if (open)
            q = d;
        else
            q = held;
    end

    // R3: open stage is transparent to the selector result
    a_r3_follow: assert property (@(posedge clk) disable iff (rst)
        open |-> (q == d));

    // R4: two closed cycles in a row keep the output still
    a_r4_keep: assert property (@(posedge clk) disable iff (rst)
        (!open && $past(!open)) |-> (q == $past(q)));

endmodule

// File: rtl/mux_hold_bank.sv
module mux_hold_bank
    import mux_hold_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] din_a,
    input  logic [NCH-1:0] din_b,
    input  logic [NCH-1:0] din_c,
    input  logic [NCH-1:0] din_d,
    input  logic [1:0]     sel,
    input  logic           hold_x,
    input  logic           hold_y,
    output logic [NCH-1:0] q,
    output logic [NCH-1:0] q_n
);

    logic [NCH-1:0] picked;
    logic [NCH-1:0] stored;
    logic           open;

    quad_selector #(.NCH(NCH)) u_sel (
        .da  (din_a),
        .db  (din_b),
        .dc  (din_c),
        .dd  (din_d),
        .sel (pick_e'(sel)),
        .y   (picked)
    );

    hold_gate u_gate (
        .rq0  (hold_x),
        .rq1  (hold_y),
        .open (open)
    );

    chan_store #(.NCH(NCH)) u_store (
        .clk  (clk),
        .rst  (rst),
        .open (open),
        .d    (picked),
        .q    (stored)
    );

    assign q   = stored;
    assign q_n = ~stored;

    // R6: clear forces both polarities
    a_r6_clear: assert property (@(posedge clk)
        rst |-> (q == '0 && q_n == '1));

    // R7: leaving reset while closed keeps zeros
    a_r7_release_closed: assert property (@(posedge clk)
        ($fell(rst) && !open) |-> (q == '0));

    // R8: complementary pair
    a_r8_complement: assert property (@(posedge clk) disable iff (rst)
        q_n == ~q);

endmodule

// File: tb/test_mux_hold_bank.sv
module test_mux_hold_bank;

    localparam int NCH = 3;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NCH-1:0] din_a = '0, din_b = '0, din_c = '0, din_d = '0;
    logic [1:0]     sel = 2'b00;
    logic           hold_x = 1'b0, hold_y = 1'b0;
    logic [NCH-1:0] q, q_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // reference model state
    logic [NCH-1:0] m_hold = '0;
    logic           m_prev_open = 1'b0;
    logic           m_prev_rst  = 1'b1;
    logic [NCH-1:0] m_prev_pick = '0;

    always #5 clk = ~clk;

    mux_hold_bank #(.NCH(NCH)) i_mux_hold_bank (
        .clk(clk), .rst(rst),
        .din_a(din_a), .din_b(din_b), .din_c(din_c), .din_d(din_d),
        .sel(sel), .hold_x(hold_x), .hold_y(hold_y),
        .q(q), .q_n(q_n)
    );

    // {sel[1], sel[0], hold_y, hold_x}: all sixteen combinations
    localparam logic [3:0] VEC [16] = '{
        4'b0000, 4'b0100, 4'b0001, 4'b1000, 4'b0010, 4'b1100, 4'b0011, 4'b1001,
        4'b1110, 4'b0110, 4'b1010, 4'b1011, 4'b1111, 4'b0111, 4'b1101, 4'b0101
    };

    function automatic logic [NCH-1:0] ref_pick(input logic [1:0] s,
        input logic [NCH-1:0] a, input logic [NCH-1:0] b,
        input logic [NCH-1:0] c, input logic [NCH-1:0] d);
        case (s)
            2'b00:   return a;
            2'b01:   return b;
            2'b10:   return c;
            default: return d;
        endcase
    endfunction

    task automatic check(input string tag, input logic [NCH-1:0] got,
                         input logic [NCH-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, got, exp);
        end
    endtask

    // One step: edge, drive, settle, compare against the model
    task automatic apply(input logic r, input logic [1:0] s,
        input logic hx, input logic hy,
        input logic [NCH-1:0] a, input logic [NCH-1:0] b,
        input logic [NCH-1:0] c, input logic [NCH-1:0] d,
        input string tag);
        logic           now_open;
        logic [NCH-1:0] now_pick;
        logic [NCH-1:0] exp;
        @(posedge clk);
        if (m_prev_open && !m_prev_rst) m_hold = m_prev_pick;
        #1;
        rst = r; sel = s; hold_x = hx; hold_y = hy;
        din_a = a; din_b = b; din_c = c; din_d = d;
        now_open = !(hx || hy);
        now_pick = ref_pick(s, a, b, c, d);
        if (r) m_hold = '0;
        exp = r ? '0 : (now_open ? now_pick : m_hold);
        #3;
        check({tag, " q"}, q, exp);
        check("R8 q_n", q_n, ~exp);
        m_prev_open = now_open;
        m_prev_rst  = r;
        m_prev_pick = now_pick;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // reset state (R6)
        #2;
        check("R6 reset q", q, '0);
        check("R6 reset q_n", q_n, '1);
        apply(1'b1, 2'b00, 1'b0, 1'b0, 3'b111, 3'b111, 3'b111, 3'b111, "R6 reset open");

        // table walk: every select and hold combination, data varying each step
        for (int i = 0; i < 16; i++) begin
            logic [3:0] v;
            v = VEC[i];
            apply(1'b0, v[3:2], v[0], v[1],
                  3'(i), 3'(i + 3), 3'(~i), 3'(i * 5), "R1 R2 R3 R4 table");
        end

        // R1: each select value on distinct patterns while open
        apply(1'b0, 2'b00, 1'b0, 1'b0, 3'b101, 3'b010, 3'b011, 3'b100, "R1 pick a");
        apply(1'b0, 2'b01, 1'b0, 1'b0, 3'b101, 3'b010, 3'b011, 3'b100, "R1 pick b");
        apply(1'b0, 2'b10, 1'b0, 1'b0, 3'b101, 3'b010, 3'b011, 3'b100, "R1 pick c");
        apply(1'b0, 2'b11, 1'b0, 1'b0, 3'b101, 3'b010, 3'b011, 3'b100, "R3 pick d");

        // R2/R5: hold_x alone freezes; data and select churn
        apply(1'b0, 2'b00, 1'b1, 1'b0, 3'b000, 3'b111, 3'b111, 3'b111, "R5 hold_x churn");
        apply(1'b0, 2'b10, 1'b1, 1'b0, 3'b111, 3'b000, 3'b000, 3'b011, "R5 hold_x churn2");
        check("R4 held value", q, 3'b100);
        // R2: hold_y alone also freezes
        apply(1'b0, 2'b01, 1'b0, 1'b1, 3'b010, 3'b001, 3'b110, 3'b000, "R2 hold_y");
        check("R5 held after sel", q, 3'b100);
        // reopen shows the live pick
        apply(1'b0, 2'b01, 1'b0, 1'b0, 3'b010, 3'b001, 3'b110, 3'b000, "R3 reopen");
        check("R3 reopen value", q, 3'b001);

        // R6: reset in transparent mode, then in held mode
        apply(1'b1, 2'b11, 1'b0, 1'b0, 3'b111, 3'b111, 3'b111, 3'b111, "R6 rst open");
        apply(1'b0, 2'b11, 1'b0, 1'b0, 3'b110, 3'b110, 3'b110, 3'b110, "R3 after rst");
        apply(1'b0, 2'b11, 1'b1, 1'b1, 3'b001, 3'b001, 3'b001, 3'b001, "R4 close");
        check("R4 closed value", q, 3'b110);
        apply(1'b1, 2'b11, 1'b1, 1'b1, 3'b001, 3'b001, 3'b001, 3'b001, "R6 rst held");

        // R7: release while closed stays zero until opening
        apply(1'b0, 2'b11, 1'b1, 1'b0, 3'b111, 3'b111, 3'b111, 3'b111, "R7 release closed");
        check("R7 zero after release", q, 3'b000);
        apply(1'b0, 2'b00, 1'b0, 1'b1, 3'b111, 3'b111, 3'b111, 3'b111, "R7 still closed");
        check("R7 zero still", q, 3'b000);
        apply(1'b0, 2'b00, 1'b0, 1'b0, 3'b101, 3'b111, 3'b111, 3'b111, "R7 opened");
        check("R7 open value", q, 3'b101);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule